// File: doc/BRIEF.md
# SD Command-Line Launcher

This unit sends one SD command at a time on the command line of a 4-bit SD bus and collects the card's answer. Software programs an integer clock ratio and a 32-bit argument. It then writes a command index, and that write is the launch. The unit divides the system clock down to the SD clock and builds the 48-bit command frame, including its CRC7. It shifts the frame out most significant bit first and then waits for the response and shifts it in.

A status word reports the outcome. Its low 32 bits carry the card status from the last response, and two upper bits flag a rejected index and a response timeout. `busy_o` stays high from the launch until the command has finished. Data-line traffic is not handled here.

Register writes use a three-entry select: 0 sets the clock ratio, 1 sets the argument, and 2 holds the command index.

Top module: `sd_cmd_launch`

## Requirements
- R1: `sd_clk_o` has a period of exactly the programmed ratio in system clock cycles. A ratio write made while `busy_o` is high is ignored.
- R2: A ratio value of 0 or 1 is stored as 2.
- R3: The transmitted frame is 48 bits, sent MSB first: bit 47 = 0, bit 46 = 1, bits 45:40 = index, bits 39:8 = argument, bits 7:1 = CRC7 (polynomial x^7+x^3+1, zero seed, computed over bits 47:8), bit 0 = 1. Index 0 with a zero argument gives 48'h400000000095. Bits change only while `sd_clk_o` is low. `sd_cmd_oe_o` is high for exactly the 48 frame bits.
- R4: Writing select 2 while idle launches the command when the written 32-bit value is 0, 2, 3, 7, 12 or 41, and clears `status_o`. Any other value launches nothing, keeps `busy_o` low and sets `status_o` to bit 32 = 1, all other bits 0.
- R5: Indices 0, 2 and 3 send an all-zero argument. Indices 7, 12 and 41 send the argument register.
- R6: Index 0 expects no response. `busy_o` falls on the SD clock edge that ends the frame, and `status_o` stays 0.
- R7: Indices 3, 7, 12 and 41 receive a 48-bit response. The line is sampled at each rising SD clock edge, and a 0 is taken as the start bit. On completion, `status_o[31:0]` = response bits 39:8.
- R8: Index 2 receives a 136-bit response. On completion, `status_o[31:0]` = bits 39:8 of that 136-bit frame.
- R9: If no start bit appears within 64 rising SD clock edges after the frame, `status_o[33]` is set, `status_o[31:0]` stays 0 and `busy_o` falls.
- R10: Index writes while `busy_o` is high are ignored. The frame in progress and its result are unchanged.
- R11: After reset: `busy_o` = 0, `status_o` = 0, `sd_cmd_oe_o` = 0 and `sd_cmd_o` = 1. While idle, `sd_cmd_oe_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 ratio, 1 argument, 2 command index |
| wr_data_i | input | 32 | Write data |
| sd_cmd_i | input | 1 | Command line input from the card |
| status_o | output | 34 | [33] timeout, [32] bad index, [31:0] card status |
| busy_o | output | 1 | Command in progress |
| sd_clk_o | output | 1 | Divided SD clock |
| sd_cmd_o | output | 1 | Command line output |
| sd_cmd_oe_o | output | 1 | Command line output enable |

## Verification
A wrong bit counter or a wrong frame register shows up on the first command as a corrupted frame or CRC, seen at the 48th rising SD edge. A divider fault changes the measured `sd_clk_o` period within two SD cycles of the launch. A stuck receive state shows as `busy_o` never falling, or as a status word that differs from the stub's response within one response length. A stuck timeout counter shows as a wrong timeout flag or a wrong wait length about 64 SD clocks after the frame.

// File: rtl/sdcl_pkg.sv
package sdcl_pkg;
  localparam int FRAME_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam logic [1:0] SEL_PER = 2'd0;
  localparam logic [1:0] SEL_ARG = 2'd1;
  localparam logic [1:0] SEL_IDX = 2'd2;

  typedef enum logic [1:0] {RSP_NONE, RSP_SHORT, RSP_LONG} rsp_kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_TX, ST_WAIT, ST_RX} state_e;

  function automatic logic [6:0] crc7_of(input logic [39:0] bits);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = bits[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction
endpackage

// File: rtl/sdcl_clk_div.sv
module sdcl_clk_div #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] per_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             sd_clk_o
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] half;

  assign half   = per_i >> 1;
  assign rise_o = (cnt_q == half - 1'b1);
  assign fall_o = (cnt_q >= per_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sd_clk_o <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + 1'b1;
      if (fall_o)      sd_clk_o <= 1'b0;
      else if (rise_o) sd_clk_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sdcl_frame.sv
module sdcl_frame
  import sdcl_pkg::*;
(
  input  logic [31:0]          idx_i,
  input  logic [31:0]          arg_i,
  output logic [FRAME_LEN-1:0] frame_o,
  output logic                 ok_o,
  output rsp_kind_e            kind_o
);
  logic [31:0] arg_eff;
  logic [39:0] head;

  always_comb begin
    ok_o    = 1'b1;
    arg_eff = arg_i;
    kind_o  = RSP_SHORT;
    unique case (idx_i)
      32'd0:          begin arg_eff = '0; kind_o = RSP_NONE; end
      32'd2:          begin arg_eff = '0; kind_o = RSP_LONG; end
      32'd3:          arg_eff = '0;
      32'd7, 32'd12,
      32'd41:         ;
      default:        ok_o = 1'b0;
    endcase
    head    = {2'b01, idx_i[5:0], arg_eff};
    frame_o = {head, crc7_of(head), 1'b1};
  end
endmodule

// File: rtl/sd_cmd_launch.sv
module sd_cmd_launch
  import sdcl_pkg::*;
#(
  parameter int PER_W       = 16,
  parameter int DEF_PER     = 8,
  parameter int RSP_TIMEOUT = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic        sd_cmd_i,
  output logic [33:0] status_o,
  output logic        busy_o,
  output logic        sd_clk_o,
  output logic        sd_cmd_o,
  output logic        sd_cmd_oe_o
);
  localparam int TO_W  = $clog2(RSP_TIMEOUT + 1);
  localparam int CNT_W = $clog2(LONG_LEN + 1);

  state_e               state_q;
  rsp_kind_e            kind_q, kind_new;
  logic [PER_W-1:0]     per_q;
  logic [31:0]          arg_q;
  logic [FRAME_LEN-1:0] tx_q, frame_new;
  logic [FRAME_LEN-1:0] rx_q, rx_next;
  logic [CNT_W-1:0]     left_q;
  logic [TO_W-1:0]      tcnt_q;
  logic [33:0]          status_q;
  logic                 idx_ok, rise, fall, idle, wr_go;

  sdcl_clk_div #(.PER_W(PER_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .per_i(per_q),
    .rise_o(rise), .fall_o(fall), .sd_clk_o(sd_clk_o)
  );

  sdcl_frame u_frame (
    .idx_i(wr_data_i), .arg_i(arg_q),
    .frame_o(frame_new), .ok_o(idx_ok), .kind_o(kind_new)
  );

  assign idle        = (state_q == ST_IDLE);
  assign wr_go       = wr_en_i && idle;
  assign rx_next     = {rx_q[FRAME_LEN-2:0], sd_cmd_i};
  assign busy_o      = !idle;
  assign sd_cmd_oe_o = (state_q == ST_TX);
  assign sd_cmd_o    = sd_cmd_oe_o ? tx_q[FRAME_LEN-1] : 1'b1;
  assign status_o    = status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      kind_q   <= RSP_NONE;
      per_q    <= PER_W'(DEF_PER);
      arg_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      left_q   <= '0;
      tcnt_q   <= '0;
      status_q <= '0;
    end else begin
      if (wr_en_i && wr_sel_i == SEL_ARG) arg_q <= wr_data_i;
      if (wr_go && wr_sel_i == SEL_PER)
        per_q <= (wr_data_i < 32'd2) ? PER_W'(2) : wr_data_i[PER_W-1:0];
      unique case (state_q)
        ST_IDLE: if (wr_go && wr_sel_i == SEL_IDX) begin
          if (idx_ok) begin
            tx_q     <= frame_new;
            kind_q   <= kind_new;
            status_q <= '0;
            state_q  <= ST_START;
          end else begin
            status_q <= {2'b01, 32'h0};
          end
        end
        ST_START: if (fall) begin
          left_q  <= CNT_W'(FRAME_LEN);
          state_q <= ST_TX;
        end
        ST_TX: if (fall) begin
          if (left_q == CNT_W'(1)) begin
            tcnt_q  <= '0;
            state_q <= (kind_q == RSP_NONE) ? ST_IDLE : ST_WAIT;
          end else begin
            tx_q   <= tx_q << 1;
            left_q <= left_q - 1'b1;
          end
        end
        ST_WAIT: if (rise) begin
          if (!sd_cmd_i) begin
            rx_q    <= rx_next;
            left_q  <= (kind_q == RSP_LONG) ? CNT_W'(LONG_LEN - 1) : CNT_W'(FRAME_LEN - 1);
            state_q <= ST_RX;
          end else if (tcnt_q == TO_W'(RSP_TIMEOUT - 1)) begin
            status_q[33] <= 1'b1;
            state_q      <= ST_IDLE;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_RX: if (rise) begin
          rx_q <= rx_next;
          if (left_q == CNT_W'(1)) begin
            status_q[31:0] <= rx_next[39:8];
            state_q        <= ST_IDLE;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_launch_chk.sv
module sd_cmd_launch_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_sel_i,
  input logic [31:0] wr_data_i,
  input logic [33:0] status_o,
  input logic        busy_o,
  input logic        sd_clk_o,
  input logic        sd_cmd_o,
  input logic        sd_cmd_oe_o
);
  logic seen_q;
  logic legal, idx_wr;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;

  assign legal  = wr_data_i inside {32'd0, 32'd2, 32'd3, 32'd7, 32'd12, 32'd41};
  assign idx_wr = wr_en_i && wr_sel_i == 2'd2 && !busy_o;

  p_oe_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_cmd_oe_o |-> busy_o);

  p_cmd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && sd_clk_o && $past(sd_clk_o)) |-> ($stable(sd_cmd_o) && $stable(sd_cmd_oe_o)));

  p_launch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr && legal) |=> (busy_o && status_o == 34'h0));

  p_bad_idx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr && !legal) |=> (!busy_o && status_o == {2'b01, 32'h0}));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sd_cmd_oe_o && sd_cmd_o));
endmodule

bind sd_cmd_launch sd_cmd_launch_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .status_o(status_o), .busy_o(busy_o),
  .sd_clk_o(sd_clk_o), .sd_cmd_o(sd_cmd_o), .sd_cmd_oe_o(sd_cmd_oe_o)
);

// File: tb/sd_cmd_launch_tb_top.sv
module sd_cmd_launch_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [31:0] wr_data_i = '0;
  logic        sd_cmd_i = 1'b1;
  logic [33:0] status_o;
  logic        busy_o, sd_clk_o, sd_cmd_o, sd_cmd_oe_o;
  int          errors = 0, checks = 0, cyc = 0;

  localparam logic [135:0] LONG_RSP =
    {8'h3F, 64'h0123456789ABCDEF, 63'h2468ACE13579BDF0, 1'b1};

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic [3:0]  per;
    logic [31:0] word;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{idx: 6'd7,  arg: 32'h12340000, per: 4'd2, word: 32'h00000700},
    '{idx: 6'd3,  arg: 32'hDEADBEEF, per: 4'd3, word: 32'h5555AAAA},
    '{idx: 6'd12, arg: 32'hABCD0001, per: 4'd5, word: 32'h00000900},
    '{idx: 6'd41, arg: 32'h40FF8000, per: 4'd1, word: 32'h80FF8000},
    '{idx: 6'd0,  arg: 32'hFFFFFFFF, per: 4'd0, word: 32'h0},
    '{idx: 6'd2,  arg: 32'hFFFFFFFF, per: 4'd3, word: 32'h0}
  };

  sd_cmd_launch dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .sd_cmd_i(sd_cmd_i), .status_o(status_o),
    .busy_o(busy_o), .sd_clk_o(sd_clk_o), .sd_cmd_o(sd_cmd_o),
    .sd_cmd_oe_o(sd_cmd_oe_o)
  );

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [6:0] r = '0;
    for (int i = 39; i >= 0; i--) begin
      logic b;
      b = d[i] ^ r[6];
      r = {r[5:0], 1'b0} ^ (b ? 7'h09 : 7'h00);
    end
    return r;
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [31:0] a;
    a = (idx == 0 || idx == 2 || idx == 3) ? 32'h0 : arg;
    return {2'b01, idx, a, ref_crc({2'b01, idx, a}), 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [31:0] word,
                         input bit respond, input bit poke,
                         output logic [47:0] frame, output int per_meas, output int wait_cyc);
    logic [47:0] f;
    logic [47:0] r48;
    int t0, t1;
    f = '0; per_meas = 0;
    wr(2'd1, arg);
    wr(2'd2, {26'h0, idx});
    wait (sd_cmd_oe_o);
    fork
      begin
        if (poke) begin wr(2'd2, 32'd41); wr(2'd0, 32'd9); end
      end
      begin
        for (int i = 0; i < 48; i++) begin
          @(posedge sd_clk_o);
          f = {f[46:0], sd_cmd_o};
          if (i == 0) t0 = cyc;
          if (i == 1) per_meas = cyc - t0;
        end
      end
    join
    frame = f;
    wait (!sd_cmd_oe_o);
    t1 = cyc;
    if (respond && idx != 0) begin
      repeat (2) @(negedge sd_clk_o);
      if (idx == 2) begin
        for (int i = 135; i >= 0; i--) begin @(negedge sd_clk_o); sd_cmd_i = LONG_RSP[i]; end
      end else begin
        r48 = {2'b00, idx, word, 7'h55, 1'b1};
        for (int i = 47; i >= 0; i--) begin @(negedge sd_clk_o); sd_cmd_i = r48[i]; end
      end
      @(negedge sd_clk_o); sd_cmd_i = 1'b1;
    end
    wait (!busy_o);
    wait_cyc = cyc - t1;
    @(negedge clk_i);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] fr;
    int pm, wc;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(busy_o == 1'b0, "R11 busy", 64'(busy_o), 64'd0);
    chk(status_o == '0, "R11 status", 64'(status_o), 64'd0);
    chk(sd_cmd_oe_o == 1'b0, "R11 oe", 64'(sd_cmd_oe_o), 64'd0);
    chk(sd_cmd_o == 1'b1, "R11 cmd", 64'(sd_cmd_o), 64'd1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    foreach (VEC[k]) begin
      logic [31:0] exp_word;
      int exp_per;
      wr(2'd0, 32'(VEC[k].per));
      exp_per  = (VEC[k].per < 2) ? 2 : int'(VEC[k].per);
      exp_word = (VEC[k].idx == 0) ? 32'h0 : (VEC[k].idx == 2) ? LONG_RSP[39:8] : VEC[k].word;
      run_cmd(VEC[k].idx, VEC[k].arg, VEC[k].word, 1'b1, 1'b0, fr, pm, wc);
      // R3 R5 frame, R1 R2 period, R6 R7 R8 status
      chk(fr == ref_frame(VEC[k].idx, VEC[k].arg), "R3 R5 frame", 64'(fr),
          64'(ref_frame(VEC[k].idx, VEC[k].arg)));
      chk(pm == exp_per, "R1 R2 sd clock period", 64'(pm), 64'(exp_per));
      chk(status_o == {2'b00, exp_word}, "R6 R7 R8 status", 64'(status_o), 64'(exp_word));
      if (VEC[k].idx == 0)
        chk(fr == 48'h400000000095, "R3 known reset frame", 64'(fr), 64'h400000000095);
    end

    // R4 unsupported index
    wr(2'd2, 32'd5);
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R4 bad index no launch", 64'(busy_o), 64'd0);
    chk(status_o == {2'b01, 32'h0}, "R4 bad index flag", 64'(status_o), 64'h100000000);
    wr(2'd2, 32'h00000107);
    @(negedge clk_i);
    chk(busy_o == 1'b0 && sd_cmd_oe_o == 1'b0, "R4 high bits reject", 64'(busy_o), 64'd0);

    // R10 writes while busy ignored, R1 ratio write ignored while busy
    wr(2'd0, 32'd3);
    run_cmd(6'd12, 32'h00010000, 32'hCAFE0000, 1'b1, 1'b1, fr, pm, wc);
    chk(fr == ref_frame(6'd12, 32'h00010000), "R10 frame unchanged", 64'(fr),
        64'(ref_frame(6'd12, 32'h00010000)));
    chk(status_o == {2'b00, 32'hCAFE0000}, "R10 status unchanged", 64'(status_o), 64'hCAFE0000);
    run_cmd(6'd3, 32'h0, 32'h00001234, 1'b1, 1'b0, fr, pm, wc);
    chk(pm == 3, "R1 ratio kept after busy write", 64'(pm), 64'd3);

    // R9 timeout
    run_cmd(6'd7, 32'h00050000, 32'h0, 1'b0, 1'b0, fr, pm, wc);
    chk(status_o == {2'b10, 32'h0}, "R9 timeout flag", 64'(status_o), 64'h200000000);
    chk(wc >= 62 * 3 && wc <= 66 * 3, "R9 timeout length", 64'(wc), 64'(64 * 3));
    chk(busy_o == 1'b0, "R9 busy cleared", 64'(busy_o), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule